// File: doc/BRIEF.md
# SDRAM Bank State Tracker with Auto-Precharge Interruption

This block watches the command stream sent to a four-bank SDRAM and keeps a model of each bank's internal state: idle, open, write burst with auto-precharge, read burst with auto-precharge, write recovery and precharging. A controller uses it to learn, bank by bank, when a new ACTIVATE is legal. It also uses it to learn which DQ cycles carry write data the memory will store, and which bank's read data is on the bus.

The burst length is four and the read latency is three clocks. A WRITE with auto-precharge is cut short when a READ or WRITE to another bank is registered. The last stored beat is the one in the clock before the cutting command. Write recovery for the cut bank is then timed from that command, not from the natural end of the burst. Recovery is followed by the precharge time, and then the bank is idle again. Commands that break the bank protocol raise a sticky error flag and are otherwise dropped.

Top module: `sdramBankTracker`

## Requirements
- R1: After reset, every bank is idle (`actOk` = 4'b1111), and `wrBeatValid`, `rdValid` and `protoErr` are low.
- R2: `cmdCode` values are 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE and 4 PRECHARGE, and 5 to 7 act as NOP. `bankAddr` selects the bank, and `apAddrBit` (address bit 10) high on a READ or WRITE requests auto-precharge. An ACTIVATE to an idle bank clears that bank's `actOk` bit in the next cycle.
- R3: A WRITE accepted by an open bank marks its own cycle and the following BURST_LEN-1 cycles as valid write beats on `wrBeatValid`, unless the burst is cut.
- R4: An accepted READ ends any write burst. The last valid beat is the cycle before the READ, and the READ cycle carries no valid write beat.
- R5: An accepted WRITE ends any running write burst, and its own beats start in its command cycle.
- R6: A bank whose write with auto-precharge is cut by a command registered in cycle I reads idle again in cycle I+T_WR+T_RP.
- R7: An uncut write with auto-precharge whose last beat is in cycle L leaves its bank idle in cycle L+1+T_WR+T_RP.
- R8: For a READ accepted in cycle R, `rdValid` is high with `rdBank` equal to its bank in cycles R+CAS_LAT through R+CAS_LAT+BURST_LEN-1. A later accepted READ takes over the data bus from its own data cycle on.
- R9: A READ with auto-precharge accepted in cycle R leaves its bank idle in cycle R+BURST_LEN+T_RP.
- R10: A READ or WRITE without auto-precharge leaves its bank open. A PRECHARGE in cycle P to an open bank makes it idle in cycle P+T_RP+1.
- R11: An ACTIVATE to a bank that is not idle, or a READ or WRITE to a bank that is not open, sets `protoErr`, which stays high until reset. The command changes no bank state and produces no data beats.
- R12: A bank's `actOk` bit stays high from cycle to cycle unless an ACTIVATE to that bank is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are registered on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdCode | input | 3 | Command code of the current cycle |
| bankAddr | input | 2 | Bank the command addresses |
| apAddrBit | input | 1 | Address bit 10: auto-precharge request on READ/WRITE |
| actOk | output | 4 | Per-bank flag: bank idle, ACTIVATE legal this cycle |
| wrBeatValid | output | 1 | The DQ beat of this cycle is stored |
| rdValid | output | 1 | Read data is on DQ this cycle |
| rdBank | output | 2 | Bank that owns the read data of this cycle |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
The assertions relate `actOk` only to ACTIVATE commands. They assume that a bank leaves idle only through an ACTIVATE and that `protoErr` can only be raised by an ACTIVATE, READ or WRITE. The beat-continuity property holds for any stimulus, because an illegal WRITE cannot start a burst. The stimulus stays legal outside one directed error case. Each scenario waits until all banks are idle and then opens the two banks it uses. It aims the cutting command only at the second, open bank, and closes with a PRECHARGE any bank left open, so no command reaches a bank in a state that would reject it.

// File: rtl/sdramTrackPkg.sv
package sdramTrackPkg;

  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmdCode_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_OPEN,
    BK_WRBURST,
    BK_RDBURST,
    BK_WREC,
    BK_PRECH
  } bankState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_BANKS-1:0] ldWrecFull;
    logic [NUM_BANKS-1:0] ldWrecShort;
    logic [NUM_BANKS-1:0] ldPrech;
    logic [NUM_BANKS-1:0] ldRdBurst;
    logic                 wrStart;
    logic                 rdStart;
    logic [BANK_W-1:0]    cmdBank;
  } trackStrobes_t;

endpackage

// File: rtl/sdramTrackCtl.sv
module sdramTrackCtl
  import sdramTrackPkg::*;
#(
  parameter int T_WR = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 apFlag,
  input  logic [NUM_BANKS-1:0] cntLast,
  input  logic                 wrLast,
  output trackStrobes_t        strobes,
  output logic [NUM_BANKS-1:0] actOk,
  output logic                 protoErr
);

  logic isAct, isRd, isWr, isPre;
  logic accRd, accWr, anyAcc, errNow;
  logic [NUM_BANKS-1:0] bankIdle, bankOpen;
  logic [NUM_BANKS-1:0] ldWrecFullV, ldWrecShortV, ldPrechV, ldRdBurstV;

  assign isAct = (cmdCode == CMD_ACT);
  assign isRd  = (cmdCode == CMD_RD);
  assign isWr  = (cmdCode == CMD_WR);
  assign isPre = (cmdCode == CMD_PRE);

  // a READ/WRITE only counts when its bank is open
  assign accRd  = isRd && bankOpen[bankAddr];
  assign accWr  = isWr && bankOpen[bankAddr];
  assign anyAcc = accRd || accWr;

  assign errNow = (isAct && !bankIdle[bankAddr]) ||
                  ((isRd || isWr) && !bankOpen[bankAddr]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    bankState_e stQ, stD;
    logic hit;
    logic ldWF, ldWS, ldP, ldRB;

    assign hit = (bankAddr == BANK_W'(b));

    always_comb begin
      stD  = stQ;
      ldWF = 1'b0;
      ldWS = 1'b0;
      ldP  = 1'b0;
      ldRB = 1'b0;
      case (stQ)
        BK_IDLE: begin
          if (isAct && hit) stD = BK_OPEN;
        end
        BK_OPEN: begin
          if (hit) begin
            if (isPre) begin
              stD = BK_PRECH;
              ldP = 1'b1;
            end else if (accRd && apFlag) begin
              stD  = BK_RDBURST;
              ldRB = 1'b1;
            end else if (accWr && apFlag) begin
              stD = BK_WRBURST;
            end
          end
        end
        BK_WRBURST: begin
          // a command to another bank cuts the burst; recovery starts now
          if (anyAcc) begin
            if (T_WR > 1) begin
              stD  = BK_WREC;
              ldWS = 1'b1;
            end else begin
              stD = BK_PRECH;
              ldP = 1'b1;
            end
          end else if (wrLast) begin
            stD  = BK_WREC;
            ldWF = 1'b1;
          end
        end
        BK_WREC, BK_RDBURST: begin
          if (cntLast[b]) begin
            stD = BK_PRECH;
            ldP = 1'b1;
          end
        end
        BK_PRECH: begin
          if (cntLast[b]) stD = BK_IDLE;
        end
        default: stD = BK_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) stQ <= BK_IDLE;
      else       stQ <= stD;
    end

    assign bankIdle[b]     = (stQ == BK_IDLE);
    assign bankOpen[b]     = (stQ == BK_OPEN);
    assign ldWrecFullV[b]  = ldWF;
    assign ldWrecShortV[b] = ldWS;
    assign ldPrechV[b]     = ldP;
    assign ldRdBurstV[b]   = ldRB;
  end

  always_comb begin
    strobes.ldWrecFull  = ldWrecFullV;
    strobes.ldWrecShort = ldWrecShortV;
    strobes.ldPrech     = ldPrechV;
    strobes.ldRdBurst   = ldRdBurstV;
    strobes.wrStart     = accWr;
    strobes.rdStart     = accRd;
    strobes.cmdBank     = bankAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       protoErr <= 1'b0;
    else if (errNow) protoErr <= 1'b1;
  end

  assign actOk = bankIdle;

endmodule

// File: rtl/sdramTrackDp.sv
module sdramTrackDp
  import sdramTrackPkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trackStrobes_t        strobes,
  output logic [NUM_BANKS-1:0] cntLast,
  output logic                 wrLast,
  output logic                 wrBeatValid,
  output logic                 rdValid,
  output logic [BANK_W-1:0]    rdBank
);

  localparam int TMAX    = (T_WR > T_RP) ? T_WR : T_RP;
  localparam int CNT_MAX = (TMAX > BURST_LEN) ? TMAX : BURST_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BEAT_W  = $clog2(BURST_LEN);

  // per-bank countdown timers
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gCnt
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (!rstN)                         cntQ <= '0;
      else if (strobes.ldWrecFull[b])    cntQ <= CNT_W'(T_WR);
      else if (strobes.ldWrecShort[b])   cntQ <= CNT_W'(T_WR - 1);
      else if (strobes.ldPrech[b])       cntQ <= CNT_W'(T_RP);
      else if (strobes.ldRdBurst[b])     cntQ <= CNT_W'(BURST_LEN - 1);
      else if (cntQ != '0)               cntQ <= cntQ - 1'b1;
    end
    assign cntLast[b] = (cntQ == CNT_W'(1));
  end

  // write beat tracking: beats left after the command cycle
  logic [BEAT_W-1:0] wrRemQ;
  always_ff @(posedge clk) begin
    if (!rstN)                wrRemQ <= '0;
    else if (strobes.wrStart) wrRemQ <= BEAT_W'(BURST_LEN - 1);
    else if (strobes.rdStart) wrRemQ <= '0;
    else if (wrRemQ != '0)    wrRemQ <= wrRemQ - 1'b1;
  end

  assign wrLast      = (wrRemQ == BEAT_W'(1));
  assign wrBeatValid = strobes.wrStart || ((wrRemQ != '0) && !strobes.rdStart);

  // read latency pipeline
  logic [CAS_LAT-1:0] pipeV;
  logic [BANK_W-1:0]  pipeB [CAS_LAT];

  for (genvar j = 0; j < CAS_LAT; j++) begin : gPipe
    if (j == 0) begin : gHead
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pipeV[0] <= 1'b0;
          pipeB[0] <= '0;
        end else begin
          pipeV[0] <= strobes.rdStart;
          pipeB[0] <= strobes.cmdBank;
        end
      end
    end else begin : gTail
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pipeV[j] <= 1'b0;
          pipeB[j] <= '0;
        end else begin
          pipeV[j] <= pipeV[j-1];
          pipeB[j] <= pipeB[j-1];
        end
      end
    end
  end

  logic [BEAT_W-1:0] rdLeftQ;
  logic [BANK_W-1:0] rdBankQ;
  logic              rdHead;

  assign rdHead = pipeV[CAS_LAT-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLeftQ <= '0;
      rdBankQ <= '0;
    end else if (rdHead) begin
      rdLeftQ <= BEAT_W'(BURST_LEN - 1);
      rdBankQ <= pipeB[CAS_LAT-1];
    end else if (rdLeftQ != '0) begin
      rdLeftQ <= rdLeftQ - 1'b1;
    end
  end

  assign rdValid = rdHead || (rdLeftQ != '0);
  assign rdBank  = rdHead ? pipeB[CAS_LAT-1] : rdBankQ;

endmodule

// File: rtl/sdramBankTracker.sv
module sdramBankTracker
  import sdramTrackPkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 apAddrBit,
  output logic [NUM_BANKS-1:0] actOk,
  output logic                 wrBeatValid,
  output logic                 rdValid,
  output logic [BANK_W-1:0]    rdBank,
  output logic                 protoErr
);

  trackStrobes_t        strobes;
  logic [NUM_BANKS-1:0] cntLast;
  logic                 wrLast;

  sdramTrackCtl #(.T_WR(T_WR)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdCode  (cmdCode),
    .bankAddr (bankAddr),
    .apFlag   (apAddrBit),
    .cntLast  (cntLast),
    .wrLast   (wrLast),
    .strobes  (strobes),
    .actOk    (actOk),
    .protoErr (protoErr)
  );

  sdramTrackDp #(
    .BURST_LEN (BURST_LEN),
    .CAS_LAT   (CAS_LAT),
    .T_WR      (T_WR),
    .T_RP      (T_RP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cntLast     (cntLast),
    .wrLast      (wrLast),
    .wrBeatValid (wrBeatValid),
    .rdValid     (rdValid),
    .rdBank      (rdBank)
  );

endmodule

// File: rtl/sdramTrackChk.sv
module sdramTrackChk
  import sdramTrackPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           cmdCode,
  input logic [BANK_W-1:0]    bankAddr,
  input logic [NUM_BANKS-1:0] actOk,
  input logic                 wrBeatValid,
  input logic                 protoErr
);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoErr) |-> ($past(cmdCode) inside {CMD_ACT, CMD_RD, CMD_WR}));

  // R3: a beat that is not a fresh WRITE must continue a running burst
  a_r3_beat_continuity: assert property (@(posedge clk) disable iff (!rstN)
    (wrBeatValid && cmdCode != CMD_WR) |-> $past(wrBeatValid));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBankChk
    a_r2_act_drops: assert property (@(posedge clk) disable iff (!rstN)
      (actOk[b] && cmdCode == CMD_ACT && bankAddr == BANK_W'(b)) |=> !actOk[b]);

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
      (actOk[b] && !(cmdCode == CMD_ACT && bankAddr == BANK_W'(b))) |=> actOk[b]);
  end

endmodule

bind sdramBankTracker sdramTrackChk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdCode     (cmdCode),
  .bankAddr    (bankAddr),
  .actOk       (actOk),
  .wrBeatValid (wrBeatValid),
  .protoErr    (protoErr)
);

// File: tb/test_sdramBankTracker.sv
module test_sdramBankTracker;

  localparam int CLK_P = 10;
  localparam int BL    = 4;
  localparam int CL    = 3;
  localparam int TWR   = 2;
  localparam int TRP   = 3;

  localparam logic [2:0] C_NOP = 3'd0;
  localparam logic [2:0] C_ACT = 3'd1;
  localparam logic [2:0] C_RD  = 3'd2;
  localparam logic [2:0] C_WR  = 3'd3;
  localparam logic [2:0] C_PRE = 3'd4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmdCode = C_NOP;
  logic [1:0] bankAddr = 2'd0;
  logic       apAddrBit = 1'b0;
  logic [3:0] actOk;
  logic       wrBeatValid, rdValid, protoErr;
  logic [1:0] rdBank;

  int vectors = 0;
  int miscompares = 0;
  int cyc = -1;

  logic [3:0] sAct;
  logic       sWr, sRd, sErr;
  logic [1:0] sRdBank;

  always #(CLK_P/2) clk = ~clk;

  sdramBankTracker #(.BURST_LEN(BL), .CAS_LAT(CL), .T_WR(TWR), .T_RP(TRP)) i_sdramBankTracker (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .bankAddr(bankAddr), .apAddrBit(apAddrBit),
    .actOk(actOk), .wrBeatValid(wrBeatValid), .rdValid(rdValid), .rdBank(rdBank), .protoErr(protoErr)
  );

  function automatic int minInt(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // expected idle offset of the written bank, counted from its WRITE cycle (R6, R7)
  function automatic int expIdleW(int gap);
    return minInt(gap, BL) + TWR + TRP;
  endfunction

  // expected idle offset of the second bank with auto-precharge (R7, R9)
  function automatic int expIdleO(int gap, bit isWr);
    return gap + BL + (isWr ? TWR : 0) + TRP;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic [2:0] c, input int bk, input logic ap);
    @(negedge clk);
    cmdCode   = c;
    bankAddr  = bk[1:0];
    apAddrBit = ap;
    #1;
    cyc++;
    sAct = actOk; sWr = wrBeatValid; sRd = rdValid; sRdBank = rdBank; sErr = protoErr;
  endtask

  task automatic waitAllIdle();
    for (int i = 0; i < 40; i++) begin
      step(C_NOP, 0, 0);
      if (sAct == 4'hF) break;
    end
    chk("R12 all idle", int'(sAct), 15);
  endtask

  task automatic scenario(input int w, input int o, input int gap, input bit oWr, input bit oAp);
    int t, idleW, idleO, preBeats, postBeats, rdFirst, rdCount, rdBad, otherBusy, p;
    string cutReq;
    idleW = -1; idleO = -1; preBeats = 0; postBeats = 0;
    rdFirst = -1; rdCount = 0; rdBad = 0; otherBusy = 0;
    waitAllIdle();
    step(C_ACT, w, 0);
    step(C_ACT, o, 0);
    chk("R2 actOk drops after ACTIVATE", int'(sAct[w]), 0);
    step(C_NOP, 0, 0);
    step(C_WR, w, 1'b1);
    t = cyc;
    preBeats = int'(sWr);
    for (int k = 1; k <= 25; k++) begin
      if (k == gap) step(oWr ? C_WR : C_RD, o, oAp);
      else          step(C_NOP, 0, 0);
      if (k < gap) preBeats += int'(sWr);
      else         postBeats += int'(sWr);
      if (sAct[w] && idleW < 0) idleW = cyc;
      if (sAct[o] && idleO < 0) idleO = cyc;
      for (int b = 0; b < 4; b++)
        if (b != w && b != o && !sAct[b]) otherBusy++;
      if (sRd) begin
        if (rdFirst < 0) rdFirst = cyc;
        rdCount++;
        if (int'(sRdBank) != o) rdBad++;
      end
    end
    cutReq = (gap >= BL) ? "R3 full burst" : (oWr ? "R5 cut by WRITE" : "R4 cut by READ");
    chk(cutReq, preBeats, minInt(gap, BL));
    chk("R5 beats of second WRITE", postBeats, oWr ? BL : 0);
    chk((gap < BL) ? "R6 cut bank idle" : "R7 uncut bank idle", idleW - t, expIdleW(gap));
    chk("R8 first read cycle", (rdFirst < 0) ? -1 : rdFirst - t, oWr ? -1 : gap + CL);
    chk("R8 read beat count", rdCount, oWr ? 0 : BL);
    chk("R8 read bank", rdBad, 0);
    chk("R12 untouched banks idle", otherBusy, 0);
    chk("R11 no false error", int'(sErr), 0);
    if (oAp) begin
      chk(oWr ? "R7 second bank idle" : "R9 read AP bank idle",
          (idleO < 0) ? -1 : idleO - t, expIdleO(gap, oWr));
    end else begin
      chk("R10 bank stays open", idleO, -1);
      step(C_PRE, o, 0);
      p = cyc;
      for (int i = 0; i < TRP; i++) step(C_NOP, 0, 0);
      chk("R10 busy during precharge", int'(sAct[o]), 0);
      step(C_NOP, 0, 0);
      chk("R10 idle after precharge", int'(sAct[o]), 1);
      chk("R10 precharge timing", cyc - p, TRP + 1);
    end
  endtask

  task automatic readTruncation();
    int r, n1, n2, first;
    n1 = 0; n2 = 0; first = -1;
    waitAllIdle();
    step(C_ACT, 1, 0);
    step(C_ACT, 2, 0);
    step(C_RD, 1, 0);
    r = cyc;
    step(C_NOP, 0, 0);
    step(C_RD, 2, 0);
    for (int k = 0; k < 12; k++) begin
      step(C_NOP, 0, 0);
      if (sRd) begin
        if (first < 0) first = cyc;
        if (sRdBank == 2'd1) n1++;
        if (sRdBank == 2'd2) n2++;
      end
    end
    chk("R8 truncated first read start", first - r, CL);
    chk("R8 truncated bank1 beats", n1, 2);
    chk("R8 takeover bank2 beats", n2, BL);
    step(C_PRE, 1, 0);
    step(C_PRE, 2, 0);
  endtask

  task automatic errorCase();
    int p, rdSeen;
    rdSeen = 0;
    waitAllIdle();
    chk("R11 flag clear before violation", int'(sErr), 0);
    step(C_ACT, 0, 0);
    step(C_ACT, 0, 0);
    step(C_RD, 3, 1'b1);
    chk("R11 error after second ACTIVATE", int'(sErr), 1);
    chk("R11 illegal READ gives no beat", int'(sWr), 0);
    for (int k = 0; k < 8; k++) begin
      step(C_NOP, 0, 0);
      if (sRd) rdSeen++;
    end
    chk("R11 illegal READ gives no data", rdSeen, 0);
    chk("R11 idle bank untouched", int'(sAct[3]), 1);
    step(C_PRE, 0, 0);
    p = cyc;
    for (int i = 0; i < TRP + 1; i++) step(C_NOP, 0, 0);
    chk("R11 bank state kept open", int'(sAct[0]), 1);
    chk("R11 error stays set", int'(sErr), 1);
    chk("R11 precharge count", cyc - p, TRP + 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int w, o, g;
    bit oWr, oAp;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 actOk after reset", int'(actOk), 15);
    chk("R1 wrBeatValid after reset", int'(wrBeatValid), 0);
    chk("R1 rdValid after reset", int'(rdValid), 0);
    chk("R1 protoErr after reset", int'(protoErr), 0);

    scenario(0, 1, 3, 1'b0, 1'b1); // READ cuts write-AP one beat early
    scenario(0, 1, 3, 1'b1, 1'b1); // WRITE cuts write-AP one beat early
    scenario(2, 3, 1, 1'b0, 1'b0); // cut right after first beat
    scenario(3, 0, 5, 1'b1, 1'b1); // uncut write-AP
    scenario(1, 2, 4, 1'b0, 1'b1); // READ just after last beat
    readTruncation();

    for (int i = 0; i < 40; i++) begin
      w   = int'($urandom % 4);
      o   = (w + 1 + int'($urandom % 3)) % 4;
      g   = 1 + int'($urandom % 5);
      oWr = 1'($urandom % 2);
      oAp = 1'($urandom % 2);
      scenario(w, o, g, oWr, oAp);
    end

    errorCase();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule